// File: doc/BRIEF.md
# Sleep and halt power-mode controller

This block sequences the low-power states of a small microcontroller subsystem. Software writes a single control register. One bit requests a halt, in which only the processor is stalled while the system clock and all peripherals keep running. Another bit requests a deep sleep, in which the system clock is gated off, the supply booster, the bus charge pump and the line transceivers are told to power down, and timers and PWM outputs are frozen with their present values. The same register holds a field that chooses which activity inputs may end a sleep. It also reports, read-only, whether the supply booster has brought the internal rails up to 3.0 V.

A halt ends on the first enabled interrupt request. A sleep ends only on activity from a selected source. The controller then releases the power-down outputs and counts a wake-up delay on the free-running wake clock. When that delay has elapsed, it restores the system clock and releases the processor stall. The delay is fixed at compile time from the clock frequency, so that execution resumes within 0.5 ms of the wake event. The processor, the analog circuits and the interrupt sources are outside the block and appear only as ports. All inputs are taken as synchronous to the wake clock.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the block is running: `cpu_stall`=0, `sysclk_en`=1, all three power-down outputs 0, `tmr_freeze`=0, and `rd_data` reads 0 (both request bits and the wake-select field cleared).
- R2: In run mode, a write with bit 1 set enters sleep at that clock edge. Sleep gives `cpu_stall`=1, `sysclk_en`=0, `booster_pd`=`pump_pd`=`xcvr_pd`=1 and `tmr_freeze`=1, and bit 1 reads back 1.
- R3: In run mode, a write with bit 0 set and bit 1 clear enters halt at that clock edge. Halt gives `cpu_stall`=1 with `sysclk_en`=1, all power-down outputs 0 and `tmr_freeze`=0, and bit 0 reads back 1.
- R4: If bits 0 and 1 are both set in one write, sleep is entered and bit 0 reads back 0.
- R5: A run-mode write with bits 0 and 1 both clear leaves the block running and loads the wake-select field, bits [8 +: NWAKE], which then reads back the written value.
- R6: In halt, any set bit of `irq_hit` at a clock edge returns the block to run mode at that edge, and bit 0 then reads 0. `wake_src` has no effect in halt.
- R7: In sleep, only a `wake_src[i]` whose wake-select bit i is 1 ends the sleep. Unselected sources and `irq_hit` leave the block asleep.
- R8: At the edge that sees selected activity, the power-down outputs fall while `sysclk_en` stays 0 and `cpu_stall` and `tmr_freeze` stay 1. Exactly WAKE_CYC = CLK_HZ/2000 edges later, run mode returns and bit 1 reads 0.
- R9: Bit 2 of `rd_data` always equals `boost_low`: 1 means the rails are below 3.0 V, 0 means the booster is good.
- R10: Bits 3 to 7 and all bits above the wake-select field read 0. Writes to them have no effect.
- R11: Writes that arrive while the block is not in run mode are ignored, and the readback is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | REG_W | Control register write value |
| rd_data | output | REG_W | Control register readback |
| boost_low | input | 1 | Booster status from analog, 1 = rails below 3.0 V |
| irq_hit | input | NIRQ | Enabled interrupt requests |
| wake_src | input | NWAKE | Activity inputs that can end sleep |
| cpu_stall | output | 1 | Holds the processor |
| sysclk_en | output | 1 | System clock gate enable |
| booster_pd | output | 1 | Booster power-down |
| pump_pd | output | 1 | Charge pump power-down |
| xcvr_pd | output | 1 | Transceiver power-down |
| tmr_freeze | output | 1 | Pauses timers and holds PWM levels |

## Verification
The bench builds the block with CLK_HZ = 16000, which gives an eight-cycle wake-up delay. This makes the exact cycle at which the stall is released observable, one edge before and one edge after terminal count. It keeps NWAKE = 4 and NIRQ = 3, so the tests can drive selected and unselected wake sources and several interrupt lines side by side. The wake-select field then sits at bits 8 to 11, with reserved bits on both sides of it.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_HALT  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_t;

  localparam int HALT_BIT  = 0;
  localparam int SLEEP_BIT = 1;
  localparam int BOOST_BIT = 2;
  localparam int SEL_LSB   = 8;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             accept,
  input  logic             halt_clr,
  input  logic             sleep_clr,
  input  logic             boost_low,
  output logic [NWAKE-1:0] wake_sel,
  output logic             halt_flag,
  output logic             sleep_flag,
  output logic [REG_W-1:0] rd_data
);
  function automatic logic [REG_W-1:0] rsvd_mask();
    logic [REG_W-1:0] m;
    m = '1;
    m[HALT_BIT]  = 1'b0;
    m[SLEEP_BIT] = 1'b0;
    m[BOOST_BIT] = 1'b0;
    for (int i = 0; i < NWAKE; i++) m[SEL_LSB+i] = 1'b0;
    return m;
  endfunction

  localparam logic [REG_W-1:0] RSVD_MASK = rsvd_mask();

  logic take;
  assign take = accept && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_sel   <= '0;
      halt_flag  <= 1'b0;
      sleep_flag <= 1'b0;
    end else if (take) begin
      wake_sel   <= wr_data[SEL_LSB +: NWAKE];
      sleep_flag <= wr_data[SLEEP_BIT];
      halt_flag  <= wr_data[HALT_BIT] & ~wr_data[SLEEP_BIT];
    end else begin
      if (halt_clr)  halt_flag  <= 1'b0;
      if (sleep_clr) sleep_flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[HALT_BIT]  = halt_flag;
    rd_data[SLEEP_BIT] = sleep_flag;
    rd_data[BOOST_BIT] = boost_low;
    rd_data[SEL_LSB +: NWAKE] = wake_sel;
  end

  // R11
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(wake_sel));

  // R10
  rsvd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((wr_data & RSVD_MASK) != '0)) |=> ((rd_data & RSVD_MASK) == '0));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_sleep,
  input  logic      wr_halt,
  input  logic      irq_any,
  input  logic      wake_hit,
  input  logic      tc,
  output pm_state_t state,
  output logic      halt_done,
  output logic      sleep_done,
  output logic      wake_start
);
  pm_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN: begin
        if (wr_en && wr_sleep)     nxt = PM_SLEEP;
        else if (wr_en && wr_halt) nxt = PM_HALT;
      end
      PM_HALT:  if (irq_any)  nxt = PM_RUN;
      PM_SLEEP: if (wake_hit) nxt = PM_WAKE;
      PM_WAKE:  if (tc)       nxt = PM_RUN;
      default:  nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PM_RUN;
    else        state <= nxt;
  end

  assign halt_done  = (state == PM_HALT)  && irq_any;
  assign sleep_done = (state == PM_WAKE)  && tc;
  assign wake_start = (state == PM_SLEEP) && wake_hit;

  // R6
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PM_HALT) && irq_any) |=> (state == PM_RUN));

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PM_SLEEP) && !wake_hit) |=> (state == PM_SLEEP));

  // R4
  sleep_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PM_RUN) && wr_en && wr_sleep && wr_halt) |=> (state == PM_SLEEP));
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int WAKE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic tc
);
  localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= LOAD;
    else if (run && (cnt != '0))     cnt <= cnt - 1'b1;
  end

  assign tc = run && (cnt == '0);

  // R8
  wake_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwr_pkg::*;
#(
  parameter int CLK_HZ = 48_000_000,
  parameter int REG_W  = 16,
  parameter int NWAKE  = 4,
  parameter int NIRQ   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             boost_low,
  input  logic [NIRQ-1:0]  irq_hit,
  input  logic [NWAKE-1:0] wake_src,
  output logic             cpu_stall,
  output logic             sysclk_en,
  output logic             booster_pd,
  output logic             pump_pd,
  output logic             xcvr_pd,
  output logic             tmr_freeze
);
  localparam int WAKE_RAW = CLK_HZ / 2000;
  localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;

  pm_state_t        state;
  logic [NWAKE-1:0] wake_sel;
  logic [NWAKE-1:0] wake_match;
  logic             halt_flag, sleep_flag;
  logic             halt_done, sleep_done, wake_start, tc;
  logic             wake_hit;

  for (genvar g = 0; g < NWAKE; g++) begin : g_wake
    assign wake_match[g] = wake_src[g] & wake_sel[g];
  end
  assign wake_hit = |wake_match;

  pwr_ctrl_reg #(.REG_W(REG_W), .NWAKE(NWAKE)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .accept     (state == PM_RUN),
    .halt_clr   (halt_done),
    .sleep_clr  (sleep_done),
    .boost_low  (boost_low),
    .wake_sel   (wake_sel),
    .halt_flag  (halt_flag),
    .sleep_flag (sleep_flag),
    .rd_data    (rd_data)
  );

  pwr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sleep   (wr_data[SLEEP_BIT]),
    .wr_halt    (wr_data[HALT_BIT]),
    .irq_any    (|irq_hit),
    .wake_hit   (wake_hit),
    .tc         (tc),
    .state      (state),
    .halt_done  (halt_done),
    .sleep_done (sleep_done),
    .wake_start (wake_start)
  );

  pwr_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_start),
    .run   (state == PM_WAKE),
    .tc    (tc)
  );

  assign cpu_stall  = (state != PM_RUN);
  assign sysclk_en  = (state == PM_RUN) || (state == PM_HALT);
  assign booster_pd = (state == PM_SLEEP);
  assign pump_pd    = (state == PM_SLEEP);
  assign xcvr_pd    = (state == PM_SLEEP);
  assign tmr_freeze = (state == PM_SLEEP) || (state == PM_WAKE);

  // R3
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_flag == (state == PM_HALT));

  // R2
  sleep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag == ((state == PM_SLEEP) || (state == PM_WAKE)));

  // R2
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(booster_pd) |-> ($past(wr_en) && $past(wr_data[SLEEP_BIT])));
endmodule

// File: tb/test_pwrmode_ctrl.sv
module test_pwrmode_ctrl;
  localparam int REG_W = 16;
  localparam int NWAKE = 4;
  localparam int NIRQ  = 3;
  localparam int WCYC  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic             boost_low = 1'b0;
  logic [NIRQ-1:0]  irq_hit = '0;
  logic [NWAKE-1:0] wake_src = '0;
  logic cpu_stall, sysclk_en, booster_pd, pump_pd, xcvr_pd, tmr_freeze;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwrmode_ctrl #(.CLK_HZ(16000), .REG_W(REG_W), .NWAKE(NWAKE), .NIRQ(NIRQ)) i_pwrmode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .boost_low(boost_low), .irq_hit(irq_hit), .wake_src(wake_src),
    .cpu_stall(cpu_stall), .sysclk_en(sysclk_en), .booster_pd(booster_pd),
    .pump_pd(pump_pd), .xcvr_pd(xcvr_pd), .tmr_freeze(tmr_freeze)
  );

  typedef struct packed {
    logic [15:0] data;
    logic        halt;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h0000, 1'b0, 16'h0000},
    '{16'h0500, 1'b0, 16'h0500},
    '{16'h0001, 1'b1, 16'h0001},
    '{16'h0301, 1'b1, 16'h0301},
    '{16'hF0F8, 1'b0, 16'h0000},
    '{16'hF0F9, 1'b1, 16'h0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    #1;
  endtask

  task automatic outs(input string req, input logic [5:0] exp);
    check(req, {26'd0, cpu_stall, sysclk_en, booster_pd, pump_pd, xcvr_pd, tmr_freeze},
          {26'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state: stall 0, clk 1, pd 0, freeze 0
    outs("R1", 6'b010000);
    check("R1", rd_data, 16'h0000);

    // R5 R3 R10 vector walk
    foreach (VEC[i]) begin
      wr(VEC[i].data);
      check(VEC[i].halt ? "R3" : "R5", rd_data, VEC[i].rd);
      outs(VEC[i].halt ? "R3" : "R10", VEC[i].halt ? 6'b110000 : 6'b010000);
      if (VEC[i].halt) begin
        @(negedge clk); irq_hit = 3'b001;
        @(negedge clk); irq_hit = '0; #1;
        outs("R6", 6'b010000);
        check("R6", rd_data, {VEC[i].rd[15:1], 1'b0});
      end
    end

    // R2 sleep entry, select source 1
    wr(16'h0202);
    outs("R2", 6'b101111);
    check("R2", rd_data, 16'h0202);

    // R7 unselected source and interrupts do not wake
    @(negedge clk); wake_src = 4'b1101; irq_hit = 3'b111;
    @(negedge clk); wake_src = '0; irq_hit = '0; #1;
    outs("R7", 6'b101111);

    // R11 write during sleep ignored
    wr(16'h0001);
    check("R11", rd_data, 16'h0202);

    // R8 wake-up sequence
    @(negedge clk); wake_src = 4'b0010;
    @(negedge clk); wake_src = '0; #1;
    outs("R8", 6'b100001);
    repeat (WCYC - 1) @(negedge clk);
    #1;
    outs("R8", 6'b100001);
    @(negedge clk); #1;
    outs("R8", 6'b010000);
    check("R8", rd_data, 16'h0200);

    // R4 both bits: sleep wins, select source 0
    wr(16'h0103);
    check("R4", rd_data, 16'h0102);
    outs("R4", 6'b101111);
    @(negedge clk); wake_src = 4'b0001;
    @(negedge clk); wake_src = '0;
    repeat (WCYC) @(negedge clk);
    #1;
    check("R4", rd_data, 16'h0100);
    outs("R4", 6'b010000);

    // R9 booster status in run and halt
    @(negedge clk); boost_low = 1'b1; #1;
    check("R9", rd_data, 16'h0104);
    wr(16'h0101);
    check("R9", rd_data, 16'h0105);

    // R6 wake sources ignored in halt, then interrupt exits
    @(negedge clk); wake_src = 4'hF;
    @(negedge clk); wake_src = '0; #1;
    outs("R6", 6'b110000);
    @(negedge clk); irq_hit = 3'b100;
    @(negedge clk); irq_hit = '0; #1;
    outs("R6", 6'b010000);
    check("R6", rd_data, 16'h0104);
    @(negedge clk); boost_low = 1'b0; #1;
    check("R9", rd_data, 16'h0100);

    // R1 reset mid-sleep returns to run
    wr(16'h0202);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    outs("R1", 6'b010000);
    check("R1", rd_data, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule